// File: doc/BRIEF.md
# Line Drive Soft Start/Stop Sequencer

This block produces the active-low horizontal drive pulse train for a line deflection output stage. It brings the stage up and down in timed phases, so that neither the output transistor nor the high-voltage circuit sees an abrupt transition. A power-on request starts a soft-start phase. In that phase the drive runs at twice the line rate with a short conducting interval. After a fixed time the drive moves to the normal line rate and duty.

A standby request starts the shutdown sequence. The drive returns to the doubled rate and the RGB drive is forced to maximum, so that the picture tube discharges the high-voltage capacitor. After the discharge interval the RGB drive is forced to minimum. After a further tail interval the horizontal drive stops, and its output is held in the non-conducting (high) state.

All rates and durations are given as parameters: the clock frequency, the line frequency, the duty percentages and the phase lengths in microseconds. The period, low-time and timer counts are derived from them during elaboration. A new rate or duty takes effect only at the end of the current period, so no runt pulse is ever produced.

Top module: `line_drive_seq`

## Requirements
- R1: While reset is held, and directly after it, drv_n is 1, drv_en is 0, rgb_max is 0 and rgb_min is 0.
- R2: While the drive is off, a clock edge that samples pwr_on=1 and stby=0 starts the soft-start phase. Beginning at the following edge, drv_n repeats a period of PER_D = (CLK_HZ/LINE_HZ)/2 cycles. It is low for the first floor(PER_D*SOFT_LOW_PCT/100) cycles of each period and high for the rest.
- R3: In the run phase, drv_n repeats a period of PER_N = CLK_HZ/LINE_HZ cycles, low for the first floor(PER_N*NORM_LOW_PCT/100) cycles of each period.
- R4: The soft-start phase lasts exactly SOFT_CYC = CLK_HZ*SOFT_US/10^6 cycles. The number of doubled-rate periods started before the first normal-rate period is therefore (SOFT_CYC-1)/PER_D+1.
- R5: A clock edge that samples stby=1 in the soft-start or run phase sets rgb_max from that edge on, for exactly CLK_HZ*DISCH_US/10^6 cycles. The drive returns to the doubled-rate period at the next period boundary.
- R6: When rgb_max clears, rgb_min is set for exactly CLK_HZ*TAIL_US/10^6 cycles. rgb_max and rgb_min are never set together.
- R7: After the tail phase, the drive completes its current period. drv_en then goes to 0 and drv_n stays 1 for as long as the drive is off. drv_en is 1 exactly while a pulse period is in progress.
- R8: The period and duty change only at a period boundary, so every low pulse lasts exactly the doubled-rate low time or the normal low time.
- R9: A standby request during soft start goes straight to the discharge phase, without passing through the run phase.
- R10: pwr_on and stby are ignored during the discharge and tail phases. While the drive is off, stby=1 blocks a simultaneous pwr_on.
- R11: Once the drive is off, a new power-on request restarts the sequence from the soft-start phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Power-on request, sampled at each edge |
| stby | input | 1 | Standby request, sampled at each edge |
| drv_n | output | 1 | Horizontal drive, low = output device conducting |
| drv_en | output | 1 | High while a drive period is in progress |
| rgb_max | output | 1 | Force RGB drive to maximum (discharge phase) |
| rgb_min | output | 1 | Force RGB drive to minimum (tail phase) |

## Verification
The phase flags follow a request at the edge that samples it, so rgb_max is due one edge after stby is sampled. The first drive pulse comes one edge later than the phase change, because the pulse generator picks up a new phase only at a period boundary. The bench keeps a behavioural model that advances on every rising edge and is compared with all four outputs at every falling edge. This puts each result in the exact cycle in which it is due. Directed checks measure run lengths at the ports: low-pulse widths, the number of doubled-rate periods, and the lengths of the rgb_max and rgb_min intervals. Each of these is checked against counts computed from the requirement formulas.

// File: rtl/lds_pkg.sv
package lds_pkg;

   typedef enum logic [2:0] {
      PH_OFF   = 3'd0,
      PH_SOFT  = 3'd1,
      PH_RUN   = 3'd2,
      PH_DISCH = 3'd3,
      PH_TAIL  = 3'd4
   } lds_phase_e;

   typedef enum logic [1:0] {
      DM_IDLE = 2'd0,
      DM_FAST = 2'd1,
      DM_NORM = 2'd2
   } lds_dmode_e;

   // drive rate requested by each sequencing phase
   function automatic lds_dmode_e phase_to_mode(lds_phase_e ph);
      case (ph)
         PH_SOFT, PH_DISCH, PH_TAIL: phase_to_mode = DM_FAST;
         PH_RUN:                     phase_to_mode = DM_NORM;
         default:                    phase_to_mode = DM_IDLE;
      endcase
   endfunction

   function automatic int cycles_of_us(int clk_hz, int us);
      longint prod;
      prod = longint'(clk_hz) * longint'(us);
      cycles_of_us = int'(prod / 64'sd1_000_000);
   endfunction

endpackage

// File: rtl/lds_phase_fsm.sv
module lds_phase_fsm
   import lds_pkg::*;
#(
   parameter int SOFT_CYC  = 1000,
   parameter int DISCH_CYC = 2000,
   parameter int TAIL_CYC  = 1000,
   localparam int MAX_CYC  = (SOFT_CYC > DISCH_CYC) ?
                             ((SOFT_CYC > TAIL_CYC) ? SOFT_CYC : TAIL_CYC) :
                             ((DISCH_CYC > TAIL_CYC) ? DISCH_CYC : TAIL_CYC),
   localparam int TW       = $clog2(MAX_CYC + 1)
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_on,
   input  logic       stby,
   output lds_phase_e phase
);

   localparam logic [TW-1:0] SOFT_LAST  = TW'(SOFT_CYC - 1);
   localparam logic [TW-1:0] DISCH_LAST = TW'(DISCH_CYC - 1);
   localparam logic [TW-1:0] TAIL_LAST  = TW'(TAIL_CYC - 1);

   lds_phase_e    ph_q;
   logic [TW-1:0] tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_OFF;
         tmr_q <= '0;
      end else begin
         case (ph_q)
            PH_OFF: begin
               tmr_q <= '0;
               if (pwr_on && !stby) ph_q <= PH_SOFT;
            end
            PH_SOFT: begin
               if (stby) begin
                  ph_q  <= PH_DISCH;
                  tmr_q <= '0;
               end else if (tmr_q == SOFT_LAST) begin
                  ph_q  <= PH_RUN;
                  tmr_q <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            PH_RUN: begin
               tmr_q <= '0;
               if (stby) ph_q <= PH_DISCH;
            end
            PH_DISCH: begin
               if (tmr_q == DISCH_LAST) begin
                  ph_q  <= PH_TAIL;
                  tmr_q <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            PH_TAIL: begin
               if (tmr_q == TAIL_LAST) begin
                  ph_q  <= PH_OFF;
                  tmr_q <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            default: begin
               ph_q  <= PH_OFF;
               tmr_q <= '0;
            end
         endcase
      end
   end

   assign phase = ph_q;

endmodule

// File: rtl/lds_pulse_gen.sv
module lds_pulse_gen
   import lds_pkg::*;
#(
   parameter int PER_FAST = 32,
   parameter int LOW_FAST = 8,
   parameter int PER_NORM = 64,
   parameter int LOW_NORM = 35,
   localparam int CW      = $clog2(PER_NORM + 1)
)(
   input  logic       clk,
   input  logic       rst_n,
   input  lds_dmode_e req_mode,
   output logic       drv_n,
   output logic       active
);

   localparam logic [CW-1:0] FAST_LAST = CW'(PER_FAST - 1);
   localparam logic [CW-1:0] NORM_LAST = CW'(PER_NORM - 1);
   localparam logic [CW-1:0] FAST_LOW  = CW'(LOW_FAST);
   localparam logic [CW-1:0] NORM_LOW  = CW'(LOW_NORM);

   lds_dmode_e    mode_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last_c;
   logic [CW-1:0] low_c;
   logic          bound_c;

   always_comb begin
      case (mode_q)
         DM_FAST: begin last_c = FAST_LAST; low_c = FAST_LOW; end
         DM_NORM: begin last_c = NORM_LAST; low_c = NORM_LOW; end
         default: begin last_c = '0;        low_c = '0;       end
      endcase
      bound_c = (mode_q == DM_IDLE) || (cnt_q == last_c);
   end

   // rate and duty are latched only at a period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= DM_IDLE;
         cnt_q  <= '0;
      end else if (bound_c) begin
         mode_q <= req_mode;
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign active = (mode_q != DM_IDLE);
   assign drv_n  = !(active && (cnt_q < low_c));

endmodule

// File: rtl/line_drive_seq.sv
module line_drive_seq
   import lds_pkg::*;
#(
   parameter int CLK_HZ        = 27_000_000,
   parameter int LINE_HZ       = 15_625,
   parameter int SOFT_LOW_PCT  = 25,
   parameter int NORM_LOW_PCT  = 55,
   parameter int SOFT_US       = 50_000,
   parameter int DISCH_US      = 100_000,
   parameter int TAIL_US       = 50_000
)(
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_on,
   input  logic stby,
   output logic drv_n,
   output logic drv_en,
   output logic rgb_max,
   output logic rgb_min
);

   localparam int PER_N     = CLK_HZ / LINE_HZ;
   localparam int PER_D     = PER_N / 2;
   localparam int LOW_N     = (PER_N * NORM_LOW_PCT) / 100;
   localparam int LOW_D     = (PER_D * SOFT_LOW_PCT) / 100;
   localparam int SOFT_CYC  = cycles_of_us(CLK_HZ, SOFT_US);
   localparam int DISCH_CYC = cycles_of_us(CLK_HZ, DISCH_US);
   localparam int TAIL_CYC  = cycles_of_us(CLK_HZ, TAIL_US);

   // elaboration-time parameter checks
   if (PER_D < 2) begin : g_bad_rate
      $error("line_drive_seq: clock too slow for the doubled line rate");
   end
   if (LOW_D < 1 || LOW_D >= PER_D) begin : g_bad_soft_duty
      $error("line_drive_seq: soft-start low time out of range");
   end
   if (LOW_N < 1 || LOW_N >= PER_N) begin : g_bad_norm_duty
      $error("line_drive_seq: normal low time out of range");
   end
   if (SOFT_CYC < 1 || DISCH_CYC < 1 || TAIL_CYC < 1) begin : g_bad_timer
      $error("line_drive_seq: every phase must last at least one cycle");
   end

   lds_phase_e st;
   lds_dmode_e req_mode;

   lds_phase_fsm #(
      .SOFT_CYC  (SOFT_CYC),
      .DISCH_CYC (DISCH_CYC),
      .TAIL_CYC  (TAIL_CYC)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwr_on (pwr_on),
      .stby   (stby),
      .phase  (st)
   );

   assign req_mode = phase_to_mode(st);

   lds_pulse_gen #(
      .PER_FAST (PER_D),
      .LOW_FAST (LOW_D),
      .PER_NORM (PER_N),
      .LOW_NORM (LOW_N)
   ) u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_mode (req_mode),
      .drv_n    (drv_n),
      .active   (drv_en)
   );

   assign rgb_max = (st == PH_DISCH);
   assign rgb_min = (st == PH_TAIL);

endmodule

// File: rtl/line_drive_seq_chk.sv
module line_drive_seq_chk
   import lds_pkg::*;
#(
   parameter int LOW_FAST = 8,
   parameter int LOW_NORM = 35
)(
   input logic       clk,
   input logic       rst_n,
   input logic       stby,
   input lds_phase_e st,
   input logic       drv_n,
   input logic       drv_en,
   input logic       rgb_max,
   input logic       rgb_min
);

   int unsigned low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      low_len <= 0;
      else if (!drv_n) low_len <= low_len + 1;
      else             low_len <= 0;
   end

   p_off_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_en |-> drv_n);

   p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rgb_max && rgb_min));

   p_min_after_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rgb_min) |-> $past(rgb_max));

   p_stby_discharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == PH_SOFT || st == PH_RUN) && stby) |=> rgb_max);

   p_no_runt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_n) |-> (low_len == LOW_FAST || low_len == LOW_NORM));

   p_shutdown_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rgb_max |=> (rgb_max || rgb_min));

endmodule

bind line_drive_seq line_drive_seq_chk #(
   .LOW_FAST (LOW_D),
   .LOW_NORM (LOW_N)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .stby    (stby),
   .st      (st),
   .drv_n   (drv_n),
   .drv_en  (drv_en),
   .rgb_max (rgb_max),
   .rgb_min (rgb_min)
);

// File: tb/line_drive_seq_test.sv
`timescale 1ns/1ps
module line_drive_seq_test;

   localparam int CLK_HZ   = 1_000_000;
   localparam int LINE_HZ  = 15_625;
   localparam int SPCT     = 25;
   localparam int NPCT     = 55;
   localparam int SOFT_US  = 1000;
   localparam int DISCH_US = 2000;
   localparam int TAIL_US  = 1000;

   // expected counts from the requirement formulas
   localparam int PER_N = CLK_HZ / LINE_HZ;
   localparam int PER_D = PER_N / 2;
   localparam int LOW_N = (PER_N * NPCT) / 100;
   localparam int LOW_D = (PER_D * SPCT) / 100;
   localparam int SOFT  = CLK_HZ / 1000 * SOFT_US / 1000;
   localparam int DIS   = CLK_HZ / 1000 * DISCH_US / 1000;
   localparam int TAIL  = CLK_HZ / 1000 * TAIL_US / 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_on = 1'b0;
   logic stby = 1'b0;
   logic drv_n, drv_en, rgb_max, rgb_min;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   line_drive_seq #(
      .CLK_HZ(CLK_HZ), .LINE_HZ(LINE_HZ),
      .SOFT_LOW_PCT(SPCT), .NORM_LOW_PCT(NPCT),
      .SOFT_US(SOFT_US), .DISCH_US(DISCH_US), .TAIL_US(TAIL_US)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .stby(stby),
      .drv_n(drv_n), .drv_en(drv_en), .rgb_max(rgb_max), .rgb_min(rgb_min)
   );

   // ---------------- behavioural reference ----------------
   // phases: 0 off, 1 soft, 2 run, 3 discharge, 4 tail
   // drive kinds: 0 stopped, 1 doubled rate, 2 line rate
   int m_ph = 0, m_el = 0, m_kind = 0, m_pos = 0;

   function automatic int period_of(int k);
      return (k == 1) ? PER_D : PER_N;
   endfunction
   function automatic int low_of(int k);
      return (k == 1) ? LOW_D : LOW_N;
   endfunction

   always @(posedge clk) begin
      int want;
      if (!rst_n) begin
         m_ph = 0; m_el = 0; m_kind = 0; m_pos = 0;
      end else begin
         want = (m_ph == 0) ? 0 : (m_ph == 2) ? 2 : 1;
         if (m_kind == 0 || m_pos == period_of(m_kind) - 1) begin
            m_kind = want; m_pos = 0;
         end else m_pos = m_pos + 1;
         m_el = m_el + 1;
         if (m_ph == 0 && pwr_on && !stby) begin m_ph = 1; m_el = 0; end
         else if ((m_ph == 1 || m_ph == 2) && stby) begin m_ph = 3; m_el = 0; end
         else if (m_ph == 1 && m_el == SOFT) begin m_ph = 2; m_el = 0; end
         else if (m_ph == 3 && m_el == DIS) begin m_ph = 4; m_el = 0; end
         else if (m_ph == 4 && m_el == TAIL) begin m_ph = 0; m_el = 0; end
      end
   end

   // ---------------- per-cycle compare and run-length monitor ----------------
   int low_run = 0, last_low = 0, fast_cnt = 0, norm_cnt = 0, bad_low = 0;
   int max_run = 0, last_max = 0, min_run = 0, last_min = 0;

   task automatic check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      bit e_n;
      string tag;
      cyc++;
      if (rst_n) begin
         e_n = !(m_kind != 0 && m_pos < low_of(m_kind));
         case (m_ph)
            0: tag = "R7 off";
            1: tag = "R2 soft";
            2: tag = "R3 run";
            3: tag = "R5 discharge";
            default: tag = "R6 tail";
         endcase
         check(drv_n == e_n, {tag, " drv_n"}, drv_n, e_n);
         check(drv_en == (m_kind != 0), {tag, " drv_en"}, drv_en, m_kind != 0);
         check(rgb_max == (m_ph == 3), {tag, " rgb_max"}, rgb_max, m_ph == 3);
         check(rgb_min == (m_ph == 4), {tag, " rgb_min"}, rgb_min, m_ph == 4);
         if (!drv_n) low_run++;
         else if (low_run != 0) begin
            last_low = low_run;
            if (low_run == LOW_D) fast_cnt++;
            else if (low_run == LOW_N) norm_cnt++;
            else begin
               bad_low++;
               $display("FAIL R8 low pulse actual=%0d expected=%0d or %0d",
                        low_run, LOW_D, LOW_N);
            end
            low_run = 0;
         end
         if (rgb_max) max_run++;
         else if (max_run != 0) begin last_max = max_run; max_run = 0; end
         if (rgb_min) min_run++;
         else if (min_run != 0) begin last_min = min_run; min_run = 0; end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic pulse_pwr();
      pwr_on = 1'b1; step(1); pwr_on = 1'b0;
   endtask

   task automatic pulse_stby();
      stby = 1'b1; step(1); stby = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100_000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      step(3);
      check(drv_n == 1 && drv_en == 0 && rgb_max == 0 && rgb_min == 0,
            "R1 during reset", {drv_n, drv_en, rgb_max, rgb_min}, 4'b1000);
      rst_n = 1'b1;
      step(2);
      check(drv_n == 1 && drv_en == 0, "R1 after reset", {drv_n, drv_en}, 2'b10);

      // R10: both requests while off -> stays off
      pwr_on = 1'b1; stby = 1'b1; step(5); pwr_on = 1'b0; stby = 1'b0;
      step(3);
      check(drv_en == 0, "R10 stby blocks pwr_on", drv_en, 0);

      // R2, R3, R4: power-up
      fast_cnt = 0; norm_cnt = 0;
      pulse_pwr();
      step(500);
      check(last_low == LOW_D, "R2 soft low width", last_low, LOW_D);
      step(SOFT + 300);
      check(last_low == LOW_N, "R3 run low width", last_low, LOW_N);
      check(fast_cnt == (SOFT - 1) / PER_D + 1, "R4 soft period count",
            fast_cnt, (SOFT - 1) / PER_D + 1);

      // R5, R6, R7, R10: shutdown with ignored requests
      pulse_stby();
      check(rgb_max == 1, "R5 rgb_max after stby", rgb_max, 1);
      step(100);
      pulse_stby();
      pwr_on = 1'b1; step(3); pwr_on = 1'b0;
      step(300);
      check(last_low == LOW_D, "R5 doubled rate during discharge", last_low, LOW_D);
      step(DIS + TAIL);
      check(last_max == DIS, "R5 R10 discharge length", last_max, DIS);
      check(last_min == TAIL, "R6 tail length", last_min, TAIL);
      step(PER_D + 5);
      check(drv_en == 0 && drv_n == 1, "R7 off after tail", {drv_en, drv_n}, 2'b01);
      step(200);
      check(drv_n == 1, "R7 held high", drv_n, 1);

      // R11, R9: restart then stby during soft start
      pulse_pwr();
      step(100);
      check(drv_en == 1 && last_low == LOW_D, "R11 restart in soft start",
            last_low, LOW_D);
      norm_cnt = 0;
      pulse_stby();
      check(rgb_max == 1, "R9 stby in soft start", rgb_max, 1);
      step(DIS + TAIL + PER_D + 5);
      check(norm_cnt == 0, "R9 no run phase", norm_cnt, 0);
      check(last_max == DIS && drv_en == 0, "R9 shutdown complete", last_max, DIS);

      check(bad_low == 0 && fast_cnt > 0, "R8 all low pulses legal", bad_low, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule